// File: doc/BRIEF.md
# Interrupt Pending and Forwarding Unit

This block gathers interrupt events into sticky pending bits, gates them with a software-written enable mask, and forwards each newly enabled pending interrupt to a processor. Forwarding takes the form of an outbound write record. The record carries a 4-bit destination, made of a 3-bit crossbar port and an even/odd processor select, together with a 6-bit interrupt number. All three fields come from a configuration register. The record also names the source bit that caused it.

Software reaches three registers through a single-beat request/response port: pending sources, enables and configuration. Pending bits are cleared by writing ones to them. The outbound side uses a valid/ready handshake and sends one interrupt at a time. When several interrupts are waiting, the lowest bit number goes first. An interrupt that becomes live because its enable is written while it is already pending leaves the block only after the response to that enable write.

Top module: `ifwd_unit`

## Requirements
- R1: A pending bit at an implemented position (bit 15 soft error, bit 31 bus system error) is set in the cycle after its event input is high and stays set whatever its enable bit holds. Event inputs at other positions are ignored and read as zero.
- R2: A write to the pending register (address 0) clears each pending bit whose write-data bit is one. If an event arrives in the same cycle as that clear, the event wins and the bit stays set.
- R3: A forward is issued when a pending bit and its enable bit (address 1, same bit positions) are both one. The enable register resets to zero, so nothing is forwarded before software enables it.
- R4: When an enable bit is written to one while its source is already pending, `fwd_valid_o` does not rise in the cycle that carries the response to that write. It rises in the following cycle.
- R5: Each rise of pending-and-enabled produces exactly one forward. A new event on a bit that is still set produces none. A forward for that bit is produced again only after the bit is cleared and set again.
- R6: Interrupts that are waiting together are forwarded one per handshake, with the lowest bit number first.
- R7: While `fwd_valid_o` is high and `fwd_ready_i` is low, `fwd_valid_o`, `fwd_dest_o`, `fwd_num_o` and `fwd_src_o` hold their values.
- R8: The configuration register (address 2) keeps only the crossbar port in bits 20:18, the odd-processor select in bit 23 and the interrupt number in bits 63:58. All other bits read as zero, all fields reset to zero, and a read of address 3 returns zero.
- R9: `fwd_dest_o` is {port, odd select}, and `fwd_num_o` is the interrupt number. Both are taken from the configuration register when the forward is loaded.
- R10: Every request is answered by `csr_rsp_o` exactly one cycle later. For a read, `csr_rdata_o` carries the register value at the time of the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ev_i | input | 32 | Interrupt event inputs, one per source bit |
| csr_req_i | input | 1 | Register request strobe |
| csr_we_i | input | 1 | 1 = write, 0 = read |
| csr_addr_i | input | 2 | 0 pending, 1 enable, 2 configuration, 3 none |
| csr_wdata_i | input | 64 | Write data |
| csr_rsp_o | output | 1 | Response strobe, one cycle after the request |
| csr_rdata_o | output | 64 | Read data returned with the response |
| fwd_valid_o | output | 1 | Outbound interrupt write is valid |
| fwd_ready_i | input | 1 | Receiver accepts the outbound write |
| fwd_dest_o | output | 4 | Destination {crossbar port, odd processor} |
| fwd_num_o | output | 6 | Interrupt number to write |
| fwd_src_o | output | 5 | Source bit that caused this forward |

## Verification
The bench enables a source that is already pending and checks that the valid signal is still low in the response cycle. A design that forwarded from the enable write directly would raise it one cycle too early. It then repeats an event on a bit that is still set, which exposes a level-sensitive design that forwards again and again instead of once. It raises two sources together while the receiver stalls: a wrong priority order, or outputs that drift during the stall, show up as a scoreboard mismatch. It also clears a bit in the same cycle that its event arrives, which catches a design that lets the clear win and loses the interrupt.

// File: rtl/ifwd_pkg.sv
package ifwd_pkg;
   typedef enum logic [1:0] {
      SEL_PEND = 2'd0,
      SEL_EN   = 2'd1,
      SEL_CFG  = 2'd2,
      SEL_NONE = 2'd3
   } csr_sel_e;
endpackage

// File: rtl/ifwd_regs.sv
module ifwd_regs #(
   parameter int unsigned      SRC_W     = 32,
   parameter int unsigned      DATA_W    = 64,
   parameter logic [SRC_W-1:0] IMPL_MASK = 32'h8000_8000,
   parameter int unsigned      PORT_LSB  = 18,
   parameter int unsigned      PORT_W    = 3,
   parameter int unsigned      ODD_BIT   = 23,
   parameter int unsigned      NUM_LSB   = 58,
   parameter int unsigned      NUM_W     = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [SRC_W-1:0]  ev_i,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [1:0]        addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              rsp_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic [SRC_W-1:0]  pend_o,
   output logic [SRC_W-1:0]  en_o,
   output logic [PORT_W-1:0] port_o,
   output logic              odd_o,
   output logic [NUM_W-1:0]  num_o
);
   import ifwd_pkg::*;

   localparam logic [DATA_W-1:0] ONE_D    = DATA_W'(1);
   localparam logic [DATA_W-1:0] CFG_MASK =
        (((ONE_D << PORT_W) - ONE_D) << PORT_LSB)
      | (ONE_D << ODD_BIT)
      | (((ONE_D << NUM_W) - ONE_D) << NUM_LSB);

   logic [SRC_W-1:0]  pend_q, en_q, clr_vec;
   logic [DATA_W-1:0] cfg_q, rd_mux;
   csr_sel_e          sel;

   assign sel     = csr_sel_e'(addr_i);
   assign clr_vec = (req_i && we_i && sel == SEL_PEND) ? wdata_i[SRC_W-1:0] : '0;

   always_comb begin
      rd_mux = '0;
      unique case (sel)
         SEL_PEND: rd_mux[SRC_W-1:0] = pend_q;
         SEL_EN:   rd_mux[SRC_W-1:0] = en_q;
         SEL_CFG:  rd_mux = cfg_q;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pend_q  <= '0;
         en_q    <= '0;
         cfg_q   <= '0;
         rsp_o   <= 1'b0;
         rdata_o <= '0;
      end else begin
         pend_q <= ((pend_q & ~clr_vec) | ev_i) & IMPL_MASK;
         if (req_i && we_i && sel == SEL_EN)  en_q  <= wdata_i[SRC_W-1:0] & IMPL_MASK;
         if (req_i && we_i && sel == SEL_CFG) cfg_q <= wdata_i & CFG_MASK;
         rsp_o   <= req_i;
         rdata_o <= (req_i && !we_i) ? rd_mux : '0;
      end
   end

   assign pend_o = pend_q;
   assign en_o   = en_q;
   assign port_o = cfg_q[PORT_LSB +: PORT_W];
   assign odd_o  = cfg_q[ODD_BIT];
   assign num_o  = cfg_q[NUM_LSB +: NUM_W];
endmodule

// File: rtl/ifwd_track.sv
module ifwd_track #(
   parameter int unsigned SRC_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SRC_W-1:0] live_i,
   input  logic [SRC_W-1:0] take_i,
   output logic [SRC_W-1:0] cand_o
);
   logic [SRC_W-1:0] live_q, fire_q;

   assign cand_o = (fire_q | (live_i & ~live_q)) & live_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         live_q <= '0;
         fire_q <= '0;
      end else begin
         live_q <= live_i;
         fire_q <= cand_o & ~take_i;
      end
   end
endmodule

// File: rtl/ifwd_pick.sv
module ifwd_pick #(
   parameter int unsigned SRC_W     = 32,
   parameter int unsigned SIDX_W    = 5,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic [SRC_W-1:0]  cand_i,
   output logic              any_o,
   output logic [SIDX_W-1:0] idx_o
);
   assign any_o = |cand_i;

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            idx_o = '0;
            for (int i = SRC_W - 1; i >= 0; i--)
               if (cand_i[i]) idx_o = SIDX_W'(i);
         end
      end else begin : g_high
         always_comb begin
            idx_o = '0;
            for (int i = 0; i < SRC_W; i++)
               if (cand_i[i]) idx_o = SIDX_W'(i);
         end
      end
   endgenerate
endmodule

// File: rtl/ifwd_unit.sv
module ifwd_unit #(
   parameter int unsigned      SRC_W     = 32,
   parameter int unsigned      DATA_W    = 64,
   parameter logic [SRC_W-1:0] IMPL_MASK = 32'h8000_8000,
   parameter int unsigned      PORT_LSB  = 18,
   parameter int unsigned      PORT_W    = 3,
   parameter int unsigned      ODD_BIT   = 23,
   parameter int unsigned      NUM_LSB   = 58,
   parameter int unsigned      NUM_W     = 6,
   parameter bit               LOW_FIRST = 1'b1,
   localparam int unsigned     SIDX_W    = $clog2(SRC_W),
   localparam int unsigned     DEST_W    = PORT_W + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [SRC_W-1:0]  ev_i,
   input  logic              csr_req_i,
   input  logic              csr_we_i,
   input  logic [1:0]        csr_addr_i,
   input  logic [DATA_W-1:0] csr_wdata_i,
   output logic              csr_rsp_o,
   output logic [DATA_W-1:0] csr_rdata_o,
   output logic              fwd_valid_o,
   input  logic              fwd_ready_i,
   output logic [DEST_W-1:0] fwd_dest_o,
   output logic [NUM_W-1:0]  fwd_num_o,
   output logic [SIDX_W-1:0] fwd_src_o
);
   initial begin
      assert (SRC_W >= 2 && SRC_W <= DATA_W) else $error("SRC_W out of range");
      assert (PORT_LSB + PORT_W <= DATA_W)   else $error("port field exceeds data");
      assert (ODD_BIT < DATA_W)              else $error("odd bit exceeds data");
      assert (NUM_LSB + NUM_W <= DATA_W)     else $error("number field exceeds data");
      assert (IMPL_MASK != '0)               else $error("no implemented source");
   end

   logic [SRC_W-1:0]  pend_q, en_q, live, cand, take;
   logic [PORT_W-1:0] port;
   logic              odd, any, load;
   logic [NUM_W-1:0]  num;
   logic [SIDX_W-1:0] idx;

   ifwd_regs #(
      .SRC_W(SRC_W), .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK),
      .PORT_LSB(PORT_LSB), .PORT_W(PORT_W), .ODD_BIT(ODD_BIT),
      .NUM_LSB(NUM_LSB), .NUM_W(NUM_W)
   ) regs_i (
      .clk_i, .rst_ni, .ev_i,
      .req_i(csr_req_i), .we_i(csr_we_i), .addr_i(csr_addr_i), .wdata_i(csr_wdata_i),
      .rsp_o(csr_rsp_o), .rdata_o(csr_rdata_o),
      .pend_o(pend_q), .en_o(en_q), .port_o(port), .odd_o(odd), .num_o(num)
   );

   assign live = pend_q & en_q;

   ifwd_track #(.SRC_W(SRC_W)) track_i (
      .clk_i, .rst_ni, .live_i(live), .take_i(take), .cand_o(cand)
   );

   ifwd_pick #(.SRC_W(SRC_W), .SIDX_W(SIDX_W), .LOW_FIRST(LOW_FIRST)) pick_i (
      .cand_i(cand), .any_o(any), .idx_o(idx)
   );

   assign load = any && (!fwd_valid_o || fwd_ready_i);
   assign take = load ? (SRC_W'(1) << idx) : '0;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         fwd_valid_o <= 1'b0;
         fwd_dest_o  <= '0;
         fwd_num_o   <= '0;
         fwd_src_o   <= '0;
      end else if (load) begin
         fwd_valid_o <= 1'b1;
         fwd_dest_o  <= {port, odd};
         fwd_num_o   <= num;
         fwd_src_o   <= idx;
      end else if (fwd_ready_i) begin
         fwd_valid_o <= 1'b0;
      end
   end
endmodule

// File: rtl/ifwd_unit_chk.sv
module ifwd_unit_chk #(
   parameter int unsigned      SRC_W     = 32,
   parameter int unsigned      DATA_W    = 64,
   parameter logic [SRC_W-1:0] IMPL_MASK = 32'h8000_8000,
   parameter int unsigned      SIDX_W    = 5,
   parameter int unsigned      DEST_W    = 4,
   parameter int unsigned      NUM_W     = 6
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              csr_req_i,
   input logic              csr_we_i,
   input logic [1:0]        csr_addr_i,
   input logic [DATA_W-1:0] csr_wdata_i,
   input logic              csr_rsp_o,
   input logic              fwd_valid_o,
   input logic              fwd_ready_i,
   input logic [DEST_W-1:0] fwd_dest_o,
   input logic [NUM_W-1:0]  fwd_num_o,
   input logic [SIDX_W-1:0] fwd_src_o,
   input logic [SRC_W-1:0]  pend_q
);
   logic [SRC_W-1:0] clr_vec;
   assign clr_vec = (csr_req_i && csr_we_i && csr_addr_i == 2'd0) ? csr_wdata_i[SRC_W-1:0] : '0;

   p_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (($past(pend_q) & ~$past(clr_vec) & ~pend_q) == '0));

   p_after_rsp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csr_req_i && csr_we_i && csr_addr_i == 2'd1) |=> !$rose(fwd_valid_o));

   p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fwd_valid_o && !fwd_ready_i) |=>
         (fwd_valid_o && $stable(fwd_dest_o) && $stable(fwd_num_o) && $stable(fwd_src_o)));

   p_impl_src_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fwd_valid_o |-> IMPL_MASK[fwd_src_o]);

   p_rsp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      csr_req_i |=> csr_rsp_o);
endmodule

bind ifwd_unit ifwd_unit_chk #(
   .SRC_W(SRC_W), .DATA_W(DATA_W), .IMPL_MASK(IMPL_MASK),
   .SIDX_W(SIDX_W), .DEST_W(DEST_W), .NUM_W(NUM_W)
) chk_i (
   .clk_i, .rst_ni, .csr_req_i, .csr_we_i, .csr_addr_i, .csr_wdata_i, .csr_rsp_o,
   .fwd_valid_o, .fwd_ready_i, .fwd_dest_o, .fwd_num_o, .fwd_src_o, .pend_q
);

// File: tb/ifwd_unit_tb.sv
module ifwd_unit_tb_top;
   logic        clk_i = 1'b0, rst_ni = 1'b0;
   logic [31:0] ev_i = '0;
   logic        csr_req_i = 1'b0, csr_we_i = 1'b0;
   logic [1:0]  csr_addr_i = '0;
   logic [63:0] csr_wdata_i = '0;
   logic        csr_rsp_o;
   logic [63:0] csr_rdata_o;
   logic        fwd_valid_o, fwd_ready_i = 1'b1;
   logic [3:0]  fwd_dest_o;
   logic [5:0]  fwd_num_o;
   logic [4:0]  fwd_src_o;

   int total = 0, bad = 0;
   logic [14:0] exp_q[$];
   logic        last_fwd_v;
   logic [63:0] rd;

   always #5 clk_i = ~clk_i;

   ifwd_unit dut_i (.*);

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic csr(input logic we, input logic [1:0] a, input logic [63:0] d,
                      output logic [63:0] r);
      @(negedge clk_i); #1;
      csr_req_i = 1'b1; csr_we_i = we; csr_addr_i = a; csr_wdata_i = d;
      @(negedge clk_i);
      check("R10 rsp", {63'd0, csr_rsp_o}, 64'd1);
      r = csr_rdata_o;
      last_fwd_v = fwd_valid_o;
      #1 csr_req_i = 1'b0;
   endtask

   task automatic pulse(input logic [31:0] v);
      @(negedge clk_i); #1 ev_i = v;
      @(negedge clk_i); #1 ev_i = '0;
   endtask

   // scoreboard monitor: samples after the driver has settled, before the next edge
   initial forever begin
      @(negedge clk_i); #2;
      if (rst_ni && fwd_valid_o && fwd_ready_i) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R5 unexpected forward act=%h exp=none", {fwd_dest_o, fwd_num_o, fwd_src_o});
         end else
            check("R6/R9 forward", {49'd0, fwd_dest_o, fwd_num_o, fwd_src_o}, {49'd0, exp_q.pop_front()});
      end
   end

   initial begin
      repeat (100000) @(posedge clk_i);
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk_i);
      #1 rst_ni = 1'b1;
      @(negedge clk_i);
      check("R3 reset valid", {63'd0, fwd_valid_o}, 64'd0);
      csr(1'b0, 2'd1, '0, rd); check("R3 enable reset", rd, 64'd0);
      csr(1'b0, 2'd0, '0, rd); check("R1 pending reset", rd, 64'd0);
      csr(1'b0, 2'd2, '0, rd); check("R8 cfg reset", rd, 64'd0);
      // R8 only the port, odd and number fields are kept
      csr(1'b1, 2'd2, '1, rd);
      csr(1'b0, 2'd2, '0, rd); check("R8 cfg mask", rd, 64'hFC00_0000_009C_0000);
      csr(1'b1, 2'd2, (64'h2A << 58) | (64'd5 << 18) | (64'd1 << 23) | 64'd1, rd);
      csr(1'b0, 2'd2, '0, rd);
      check("R8 cfg fields", rd, (64'h2A << 58) | (64'd5 << 18) | (64'd1 << 23));
      // R1 event with enable off is held, no forward
      pulse(32'h0000_8000);
      repeat (3) @(negedge clk_i);
      csr(1'b0, 2'd0, '0, rd); check("R1 sticky while disabled", rd, 64'h8000);
      // R4 enabling a pending source: forward only after the response
      exp_q.push_back({4'hB, 6'h2A, 5'd15});
      csr(1'b1, 2'd1, 64'h8000, rd);
      check("R4 no valid in rsp cycle", {63'd0, last_fwd_v}, 64'd0);
      @(negedge clk_i);
      check("R4 valid next cycle", {63'd0, fwd_valid_o}, 64'd1);
      // R5 repeat event on a set bit: no new forward
      repeat (2) @(negedge clk_i);
      pulse(32'h0000_8000);
      repeat (4) @(negedge clk_i);
      check("R5 no refire", {63'd0, fwd_valid_o}, 64'd0);
      // R2 clear, R5 re-set forwards again
      csr(1'b1, 2'd0, 64'h8000, rd);
      csr(1'b0, 2'd0, '0, rd); check("R2 w1c clear", rd, 64'd0);
      exp_q.push_back({4'hB, 6'h2A, 5'd15});
      pulse(32'h0000_8000);
      repeat (4) @(negedge clk_i);
      check("R5 refire done", {32'd0, exp_q.size()}, 64'd0);
      // R6 R7 two together under stall
      csr(1'b1, 2'd1, '1, rd);
      csr(1'b0, 2'd1, '0, rd); check("R3 enable mask", rd, 64'h8000_8000);
      csr(1'b1, 2'd0, '1, rd);
      #1 fwd_ready_i = 1'b0;
      exp_q.push_back({4'hB, 6'h2A, 5'd15});
      exp_q.push_back({4'hB, 6'h2A, 5'd31});
      pulse(32'h8000_8000);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk_i);
         check("R7 hold valid", {63'd0, fwd_valid_o}, 64'd1);
         check("R6 lowest first held", {59'd0, fwd_src_o}, 64'd15);
      end
      #1 fwd_ready_i = 1'b1;
      repeat (4) @(negedge clk_i);
      check("R6 both sent", {32'd0, exp_q.size()}, 64'd0);
      // R2 event and clear in the same cycle: event wins
      @(negedge clk_i); #1;
      ev_i = 32'h0000_8000;
      csr_req_i = 1'b1; csr_we_i = 1'b1; csr_addr_i = 2'd0; csr_wdata_i = 64'h8000;
      @(negedge clk_i); #1; ev_i = '0; csr_req_i = 1'b0;
      csr(1'b0, 2'd0, '0, rd); check("R2 event beats clear", rd, 64'h8000_8000);
      // R1 unimplemented event position ignored
      pulse(32'h0000_0001);
      csr(1'b0, 2'd0, '0, rd); check("R1 unimplemented ignored", rd, 64'h8000_8000);
      csr(1'b0, 2'd3, '0, rd); check("R8 addr3 zero", rd, 64'd0);
      repeat (4) @(negedge clk_i);
      check("R5 no stray forwards", {32'd0, exp_q.size()}, 64'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule